// File: doc/BRIEF.md
# Low-Power Event Counter with Register Interface

This block is an event counter that software drives over a simple word-addressed register bus. An edge detector or quadrature decoder outside the block delivers single-cycle count strobes, with a direction bit. The counter follows those strobes while it runs. It wraps at a programmable ceiling (the reload value) and raises sticky status flags on wrap and on a compare match.

Reload and compare values cross into the counting domain through a fixed-latency handshake. Such a write is accepted only while the block is enabled. The new value takes effect some cycles later, and at that moment a write-complete flag rises in the status register. Software must clear these flags through a separate clear register. The configuration word is frozen while the block is enabled. Counting starts only when software sets a run bit after enabling, and clearing the enable bit stops it.

Register word addresses: 0 control (bit 0 enable, bit 1 start/run), 1 configuration (bit 0 encoder mode, bit 1 external count mode, bits 3:2 edge polarity, bits 6:4 prescaler), 2 reload, 3 compare, 4 count, 5 status, 6 status clear. Status bits: bit 0 compare match, bit 1 reload (wrap) match, bit 2 compare write complete, bit 3 reload write complete.

Top module: `lpc_counter_regif`

## Requirements
- R1: After reset, control, configuration, compare, count and status read as 0, and reload reads as the maximum reload value 0xFFFF.
- R2: A write to reload (address 2) or compare (address 3) while the enable bit (control bit 0) is 0 is ignored: the value does not change and no write-complete flag (status bits 3 and 2) rises.
- R3: An accepted reload or compare write becomes visible in its register, and raises its write-complete flag (reload: status bit 3, compare: status bit 2), at the third clock edge after the edge that sampled the write, and not earlier.
- R4: Writing address 6 clears each status bit whose position holds a 1 in the written data. Bits written as 0 are left unchanged.
- R5: The configuration register (address 1, bits 6:0) accepts writes only while the enable bit is 0. Writes while enabled are ignored.
- R6: Setting the enable bit alone does not count. A write with bits 0 and 1 both set, made while already enabled, starts the counter, and control bit 1 then reads 1. Writing enable 0 clears both bits and freezes the count.
- R7: When running, a strobe with the counter at or above the reload value makes the count 0 and sets status bit 1. Any other up-strobe adds one.
- R8: In encoder mode (configuration bit 0 = 1) a strobe with the direction input high counts down, and from 0 it loads the reload value and sets status bit 1. With encoder mode off, the direction input is ignored and strobes count up.
- R9: Status bit 0 is set when a counted strobe brings the count equal to the active compare value.
- R10: A reload write whose data exceeds 0xFFFF is ignored, with no value change and no flag.
- R11: The count register (address 4) is read-only. Writes to it leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cnt_step | input | 1 | Count strobe from the edge or decoder stage |
| cnt_down | input | 1 | Direction of the strobe, high for down (encoder mode only) |

## Verification
The assertions take for granted that the bus address and write strobe are never unknown. They also assume that a count strobe is a single-cycle pulse qualified by the direction input in the same cycle. The wrap and write-complete properties additionally assume that software does not disable the block while a reload or compare write is still in flight. The stimulus keeps within this. It issues one bus operation at a time, between clock edges, and drives count strobes as isolated one-cycle pulses. It waits at least three edges after every reload or compare write before disabling. Random direction sequences use a fixed seed, with a small reload value, so that wraps in both directions and compare hits occur often.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_CFG    = 3'd1,
        RA_RELOAD = 3'd2,
        RA_CMP    = 3'd3,
        RA_COUNT  = 3'd4,
        RA_STATUS = 3'd5,
        RA_CLEAR  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [2:0] presc;
        logic [1:0] pol;
        logic       ext_mode;
        logic       enc_mode;
    } cfg_t;

    typedef struct packed {
        logic reload_ok;
        logic cmp_ok;
        logic wrap_hit;
        logic cmp_hit;
    } status_t;

    localparam int CFG_W    = $bits(cfg_t);
    localparam int STATUS_W = $bits(status_t);
    localparam int SLOT_RELOAD = 0;
    localparam int SLOT_CMP    = 1;
    localparam int NUM_SLOTS   = 2;

    function automatic logic is_write(input logic wr, input logic [2:0] addr,
                                      input reg_addr_e target);
        return wr && (addr == target);
    endfunction

endpackage

// File: rtl/lpc_sync_slot.sv
module lpc_sync_slot #(
    parameter int DATA_W = 16,
    parameter int LAT    = 3,
    localparam int CW    = $clog2(LAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cancel,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              apply,
    output logic [DATA_W-1:0] data
);
    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= CW'(LAT);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (load) begin
            data <= load_data;
        end
    end

    assign busy  = (remain_q != '0);
    assign apply = (remain_q == CW'(1)) && !load && !cancel;

endmodule

// File: rtl/lpc_count_core.sv
module lpc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  logic             down,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt,
    output logic             match_evt
);
    logic             advance;
    logic [CNT_W-1:0] count_n;

    assign advance = run && step;

    always_comb begin
        wrap_evt = 1'b0;
        if (down) begin
            if (count == '0) begin
                count_n  = reload;
                wrap_evt = advance;
            end else begin
                count_n = count - 1'b1;
            end
        end else begin
            if (count >= reload) begin
                count_n  = '0;
                wrap_evt = advance;
            end else begin
                count_n = count + 1'b1;
            end
        end
        match_evt = advance && (count_n == cmp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (advance) begin
            count <= count_n;
        end
    end

endmodule

// File: rtl/lpc_counter_regif.sv
module lpc_counter_regif
    import lpc_pkg::*;
#(
    parameter int          CNT_W      = 16,
    parameter int          SYNC_LAT   = 3,
    parameter int unsigned MAX_RELOAD = 32'h0000_FFFF,
    parameter int          DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_step,
    input  logic              cnt_down
);
    localparam logic [CNT_W-1:0] RELOAD_RST = CNT_W'(MAX_RELOAD);

    logic             ena_q, run_q;
    cfg_t             cfg_q;
    status_t          status_q, status_set, status_clr;
    logic [CNT_W-1:0] reload_act, cmp_act, count;
    logic             wrap_evt, match_evt;
    logic             reload_in_range;

    logic [NUM_SLOTS-1:0] slot_load, slot_busy, slot_apply;
    logic [CNT_W-1:0]     slot_val [NUM_SLOTS];

    assign reload_in_range = (32'(bus_wdata) <= MAX_RELOAD);
    assign slot_load[SLOT_RELOAD] = ena_q && reload_in_range &&
                                    is_write(bus_wr, bus_addr, RA_RELOAD);
    assign slot_load[SLOT_CMP]    = ena_q && is_write(bus_wr, bus_addr, RA_CMP);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        lpc_sync_slot #(.DATA_W(CNT_W), .LAT(SYNC_LAT)) i_slot (
            .clk       (clk),
            .rst       (rst),
            .cancel    (!ena_q),
            .load      (slot_load[s]),
            .load_data (bus_wdata[CNT_W-1:0]),
            .busy      (slot_busy[s]),
            .apply     (slot_apply[s]),
            .data      (slot_val[s])
        );
    end

    // control: run needs enable already set; clearing enable stops everything
    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= 1'b0;
            run_q <= 1'b0;
        end else if (is_write(bus_wr, bus_addr, RA_CTRL)) begin
            ena_q <= bus_wdata[0];
            run_q <= bus_wdata[0] && (run_q || (ena_q && bus_wdata[1]));
        end
    end

    // configuration frozen while enabled
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (!ena_q && is_write(bus_wr, bus_addr, RA_CFG)) begin
            cfg_q <= cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_act <= RELOAD_RST;
            cmp_act    <= '0;
        end else begin
            if (slot_apply[SLOT_RELOAD]) reload_act <= slot_val[SLOT_RELOAD];
            if (slot_apply[SLOT_CMP])    cmp_act    <= slot_val[SLOT_CMP];
        end
    end

    lpc_count_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst       (rst),
        .run       (run_q),
        .step      (cnt_step),
        .down      (cfg_q.enc_mode && cnt_down),
        .reload    (reload_act),
        .cmp       (cmp_act),
        .count     (count),
        .wrap_evt  (wrap_evt),
        .match_evt (match_evt)
    );

    always_comb begin
        status_set.reload_ok = slot_apply[SLOT_RELOAD];
        status_set.cmp_ok    = slot_apply[SLOT_CMP];
        status_set.wrap_hit  = wrap_evt;
        status_set.cmp_hit   = match_evt;
        status_clr = is_write(bus_wr, bus_addr, RA_CLEAR) ?
                     status_t'(bus_wdata[STATUS_W-1:0]) : '0;
    end

    // a new event in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~status_clr) | status_set;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTRL:   bus_rdata[1:0]          = {run_q, ena_q};
            RA_CFG:    bus_rdata[CFG_W-1:0]    = cfg_q;
            RA_RELOAD: bus_rdata[CNT_W-1:0]    = reload_act;
            RA_CMP:    bus_rdata[CNT_W-1:0]    = cmp_act;
            RA_COUNT:  bus_rdata[CNT_W-1:0]    = count;
            RA_STATUS: bus_rdata[STATUS_W-1:0] = status_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic             cnt_step,
    input logic             cnt_down,
    input logic             ena_q,
    input logic             run_q,
    input logic [6:0]       cfg_bits,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload_act,
    input logic [3:0]       status_bits,
    input logic [1:0]       slot_busy
);
    // R2: a reload write while disabled never starts the sync countdown
    a_r2_reload_ignored_off: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd2 && !ena_q) |=> !slot_busy[0]);

    // R3: reload write-complete only rises out of a pending countdown
    a_r3_ok_after_pending: assert property (@(posedge clk) disable iff (rst)
        $rose(status_bits[3]) |-> $past(slot_busy[0]));

    // R5: configuration held while enabled
    a_r5_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        ena_q |=> $stable(cfg_bits));

    // R6: running implies enabled, and count frozen when not running
    a_r6_run_needs_enable: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ena_q);
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> $stable(count));

    // R7: up-strobe at the ceiling wraps to zero and flags it
    a_r7_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_step && !(cfg_bits[0] && cnt_down) && count == reload_act)
        |=> (count == '0 && status_bits[1]));

endmodule

bind lpc_counter_regif lpc_checker #(.CNT_W(CNT_W)) i_lpc_checker (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .cnt_step    (cnt_step),
    .cnt_down    (cnt_down),
    .ena_q       (ena_q),
    .run_q       (run_q),
    .cfg_bits    (cfg_q),
    .count       (count),
    .reload_act  (reload_act),
    .status_bits (status_q),
    .slot_busy   (slot_busy)
);

// File: tb/test_lpc_counter_regif.sv
`timescale 1ns/1ps
module test_lpc_counter_regif;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        cnt_step = 1'b0;
    logic        cnt_down = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lpc_counter_regif i_lpc_counter_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_step  (cnt_step),
        .cnt_down  (cnt_down)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic step(input logic dn);
        @(negedge clk);
        cnt_step = 1'b1; cnt_down = dn;
        @(negedge clk);
        cnt_step = 1'b0; cnt_down = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] m_next(input logic [15:0] c, input logic dn,
                                           input logic [15:0] rl, output logic wrap);
        wrap = 1'b0;
        if (dn) begin
            if (c == 16'd0) begin wrap = 1'b1; return rl; end
            return c - 16'd1;
        end
        if (c >= rl) begin wrap = 1'b1; return 16'd0; end
        return c + 16'd1;
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] mc;
        logic [3:0]  ms;
        logic        w;
        logic        dn;
        int          seed;
        seed = $urandom(32'h5EED);

        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rdchk("R1 ctrl",   3'd0, 32'h0);
        rdchk("R1 cfg",    3'd1, 32'h0);
        rdchk("R1 reload", 3'd2, 32'h0000_FFFF);
        rdchk("R1 cmp",    3'd3, 32'h0);
        rdchk("R1 count",  3'd4, 32'h0);
        rdchk("R1 status", 3'd5, 32'h0);

        // R2 writes while disabled ignored
        wr(3'd2, 32'd10);
        wr(3'd3, 32'd4);
        idle(4);
        rdchk("R2 reload unchanged", 3'd2, 32'h0000_FFFF);
        rdchk("R2 cmp unchanged",    3'd3, 32'h0);
        rdchk("R2 no flags",         3'd5, 32'h0);

        // R5 configuration write while disabled, then locked
        wr(3'd1, 32'h0000_0001);
        rdchk("R5 cfg accepted", 3'd1, 32'h1);
        wr(3'd0, 32'h1);
        rdchk("R6 enable only", 3'd0, 32'h1);
        wr(3'd1, 32'h0000_007E);
        rdchk("R5 cfg locked", 3'd1, 32'h1);

        // R10 out-of-range reload ignored
        wr(3'd2, 32'h0002_0000);
        idle(4);
        rdchk("R10 reload unchanged", 3'd2, 32'h0000_FFFF);
        rdchk("R10 no flag",          3'd5, 32'h0);

        // R3 timing of reload write
        wr(3'd2, 32'd5);
        idle(2);
        rdchk("R3 reload old at edge+2", 3'd2, 32'h0000_FFFF);
        rdchk("R3 no flag at edge+2",    3'd5, 32'h0);
        idle(1);
        rdchk("R3 reload new at edge+3", 3'd2, 32'd5);
        rdchk("R3 reload_ok at edge+3",  3'd5, 32'h8);

        // R3 timing of compare write
        wr(3'd3, 32'd3);
        idle(2);
        rdchk("R3 cmp old at edge+2", 3'd3, 32'h0);
        idle(1);
        rdchk("R3 cmp new at edge+3", 3'd3, 32'd3);
        rdchk("R3 cmp_ok at edge+3",  3'd5, 32'hC);

        // R4 selective clear
        wr(3'd6, 32'h4);
        rdchk("R4 clear cmp_ok only", 3'd5, 32'h8);
        wr(3'd6, 32'h8);
        rdchk("R4 clear reload_ok", 3'd5, 32'h0);

        // R6 enabled but not started: no counting
        step(1'b0);
        step(1'b0);
        rdchk("R6 no count before start", 3'd4, 32'h0);
        wr(3'd0, 32'h3);
        rdchk("R6 run bit set", 3'd0, 32'h3);

        // R11 count read-only
        wr(3'd4, 32'd7);
        rdchk("R11 count write ignored", 3'd4, 32'h0);

        // R8 down from zero in encoder mode
        step(1'b1);
        rdchk("R8 down wrap to reload", 3'd4, 32'd5);
        rdchk("R8 wrap flag",           3'd5, 32'h2);
        wr(3'd6, 32'hF);

        // R7 R8 R9 random directions against the model
        mc = 16'd5;
        ms = 4'h0;
        for (int i = 0; i < 80; i++) begin
            dn = 1'($urandom);
            step(dn);
            mc = m_next(mc, dn, 16'd5, w);
            if (w) ms[1] = 1'b1;
            if (mc == 16'd3) ms[0] = 1'b1;
            rdchk("R7/R8 random count", 3'd4, {16'h0, mc});
            rdchk("R9 random flags",    3'd5, {28'h0, ms});
            if (i % 10 == 9) begin
                wr(3'd6, 32'h3);
                ms = 4'h0;
            end
        end

        // R7 directed up wrap
        wr(3'd6, 32'hF);
        while (mc != 16'd5) begin
            step(1'b0);
            mc = m_next(mc, 1'b0, 16'd5, w);
        end
        wr(3'd6, 32'hF);
        step(1'b0);
        rdchk("R7 up wrap to zero", 3'd4, 32'h0);
        rdchk("R7 wrap flag",       3'd5, 32'h2);

        // R9 compare hit on up count
        wr(3'd6, 32'hF);
        step(1'b0); step(1'b0); step(1'b0);
        rdchk("R9 count at compare", 3'd4, 32'd3);
        rdchk("R9 compare flag",     3'd5, 32'h1);

        // R6 disable stops counting
        wr(3'd0, 32'h0);
        rdchk("R6 ctrl cleared", 3'd0, 32'h0);
        step(1'b0);
        rdchk("R6 frozen when disabled", 3'd4, 32'd3);

        // R8 direction ignored outside encoder mode
        wr(3'd1, 32'h0);
        rdchk("R5 cfg writable when disabled", 3'd1, 32'h0);
        wr(3'd0, 32'h1);
        wr(3'd0, 32'h3);
        step(1'b1);
        rdchk("R8 direction ignored", 3'd4, 32'd4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule